// File: doc/BRIEF.md
# Interrupt-Capable Pin Controller

This block controls 32 general-purpose pins through a small word-addressed register bus. Software sets each pin as an output or an input. Output pins drive a stored data value. Input pins pass through a two-stage synchronizer, and their settled level is kept in a sampled-level register that software can read.

Each input pin has its own interrupt condition. It can be a low level, a high level, a rising edge or a falling edge, and an override bit turns it into any-edge detection. A detected condition sets a sticky flag. Software clears a flag by writing a one to it. The flags are ANDed with a mask and drive one interrupt line, or two lines split by pin half when a parameter asks for that.

The bus has a select, a write strobe, a word address, write data and combinational read data. Every access is a full 32-bit word.

Top module: `pio_irq_ctrl`

## Requirements
- R1: After reset the data, direction, both condition words, mask and any-edge registers read zero. Both interrupt outputs are low, and `pad_oe` and `pad_out` are zero.
- R2: `pad_oe` equals the direction register, where 1 means output. `pad_out` carries the data bit on output pins and 0 on input pins.
- R3: A read of word 0 returns the data bit for each output pin and the sampled level for each input pin.
- R4: A read of word 2 returns the sampled levels with every output pin's bit forced to 0. A pad change appears there after the third rising clock edge.
- R5: Pin n's condition code is held in bits 2n+1:2n of {word 4, word 3}, so word 3 covers pins 0–15 and word 4 covers pins 16–31. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. After reset all pins are set to low level.
- R6: When bit n of word 7 (any-edge) is set, pin n flags on both rising and falling changes, whatever its condition code says.
- R7: The flags at word 6 are sticky. Writing 1 to a bit clears it and writing 0 leaves it alone. A level condition that is still true sets the bit again in the same cycle, so the set wins over the clear.
- R8: Pins configured as outputs never set a flag.
- R9: With SPLIT_IRQ=0, `irq_lo` is the OR of flags AND mask (word 5), and `irq_hi` stays 0. With SPLIT_IRQ=1, `irq_lo` covers pins 0–15 and `irq_hi` covers pins 16–31.
- R10: With HAS_ANYEDGE=0, word 7 reads zero and writes to it have no effect on detection.
- R11: Word addresses 8 and above read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Bus select |
| wr | input | 1 | Write strobe, qualified by sel |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not reading |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Driven pad levels |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for all pins, or for pins 0–15 when split |
| irq_hi | output | 1 | Interrupt for pins 16–31 when split, else 0 |

## Verification
The hardest situation to reach from the ports is a write-one clear that lands on the same edge as a detection. The bench holds a level condition true, so a fresh detection happens on every edge, then clears the flag and reads it back at once. The level must still be flagged. For the any-edge override, the bench first arms the pins under a rising-edge code, clears them, and then lets them fall. Only a pin under the override can flag on that fall. A second instance, built without the override and with split interrupts, sees the same stimulus, which shows both parameter variants side by side.

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl #(
  parameter int DW          = 32,
  parameter int ADDR_W      = 4,
  parameter bit HAS_ANYEDGE = 1'b1,
  parameter bit SPLIT_IRQ   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     pad_in,
  output logic [DW-1:0]     pad_out,
  output logic [DW-1:0]     pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = DW / 2;
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CFGL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CFGH = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_ANY  = ADDR_W'(7);

  logic [DW-1:0]   out_q, dir_q, s1_q, s2_q, pad_q, mask_q, flag_q, any_q, hit, clr, act;
  logic [2*DW-1:0] cfg_q;

  wire we = sel & wr;
  assign clr = (we && addr == A_FLAG) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      pad_q  <= '0;
      cfg_q  <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      pad_q  <= s2_q;
      flag_q <= (flag_q & ~clr) | hit;
      if (we) begin
        case (addr)
          A_DATA: out_q <= wdata;
          A_DIR:  dir_q <= wdata;
          A_CFGL: cfg_q[DW-1:0] <= wdata;
          A_CFGH: cfg_q[2*DW-1:DW] <= wdata;
          A_MASK: mask_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  generate
    if (HAS_ANYEDGE) begin : g_any
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) any_q <= '0;
        else if (we && addr == A_ANY) any_q <= wdata;
      end
    end else begin : g_no_any
      assign any_q = '0;
    end
  endgenerate

  for (genvar i = 0; i < DW; i++) begin : g_pin
    wire chg  = s2_q[i] ^ pad_q[i];
    wire pol  = cfg_q[2*i];
    wire edge_mode = cfg_q[2*i+1];
    assign hit[i] = ~dir_q[i] & (any_q[i]  ? chg :
                                 edge_mode ? (chg & (s2_q[i] != pol)) :
                                             (s2_q[i] == pol));
  end

  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      case (addr)
        A_DATA: rdata = (out_q & dir_q) | (pad_q & ~dir_q);
        A_DIR:  rdata = dir_q;
        A_LVL:  rdata = pad_q & ~dir_q;
        A_CFGL: rdata = cfg_q[DW-1:0];
        A_CFGH: rdata = cfg_q[2*DW-1:DW];
        A_MASK: rdata = mask_q;
        A_FLAG: rdata = flag_q;
        A_ANY:  rdata = any_q;
        default: rdata = '0;
      endcase
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = out_q & dir_q;
  assign act     = flag_q & mask_q;

  generate
    if (SPLIT_IRQ) begin : g_split
      assign irq_lo = |act[HALF-1:0];
      assign irq_hi = |act[DW-1:HALF];
    end else begin : g_single
      assign irq_lo = |act;
      assign irq_hi = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pio_irq_ctrl_chk.sv
module pio_irq_ctrl_chk #(
  parameter int DW     = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic [DW-1:0]     pad_oe,
  input logic [DW-1:0]     flag_q,
  input logic [DW-1:0]     dir_q,
  input logic              irq_lo,
  input logic              irq_hi
);
  a_r2_oe_tracks_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == ADDR_W'(1)) |=> (pad_oe == $past(wdata)));

  a_r4_level_read_hides_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr == ADDR_W'(2)) |-> ((rdata & pad_oe) == '0));

  a_r8_outputs_never_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & $past(dir_q)) == '0));

  a_r9_zero_mask_quiets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == ADDR_W'(5) && wdata == '0) |=> (!irq_lo && !irq_hi));

  a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr > ADDR_W'(7)) |-> (rdata == '0));
endmodule

bind pio_irq_ctrl pio_irq_ctrl_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pad_oe(pad_oe), .flag_q(flag_q), .dir_q(dir_q),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/test_pio_irq_ctrl.sv
module test_pio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe, rdata_b, pad_out_b, pad_oe_b;
  logic        irq_lo, irq_hi, irq_lo_b, irq_hi_b;
  int total = 0, bad = 0;
  logic [31:0] va, vb;

  always #4 clk = ~clk;

  pio_irq_ctrl i_pio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  pio_irq_ctrl #(.HAS_ANYEDGE(1'b0), .SPLIT_IRQ(1'b1)) i_pio_irq_ctrl_b (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata_b), .pad_in(pad_in), .pad_out(pad_out_b), .pad_oe(pad_oe_b),
    .irq_lo(irq_lo_b), .irq_hi(irq_hi_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1; va = rdata; vb = rdata_b;
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic do_reset();
    pad_in = '0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    for (int a = 0; a < 8; a++) begin
      if (a == 6) continue;
      rreg(4'(a));
      chk("R1 register clear", va, 32'h0);
    end
    chk("R1 irq_lo", {31'b0, irq_lo}, 32'h0);
    chk("R1 irq_hi", {31'b0, irq_hi}, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
  endtask

  task automatic t_output();
    do_reset();
    wreg(4'd1, 32'hFFFF_0000);
    wreg(4'd0, 32'hA5A5_5A5A);
    pad_in = 32'h1234_5678;
    settle();
    @(negedge clk);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'hA5A5_0000);
    rreg(4'd0); chk("R3 data mix", va, 32'hA5A5_5678);
    rreg(4'd2); chk("R4 level masked", va, 32'h0000_5678);
  endtask

  task automatic t_sync();
    do_reset();
    settle();
    @(negedge clk); pad_in = 32'h0000_0001;
    repeat (2) @(posedge clk);
    rreg(4'd2); chk("R4 not yet visible", va, 32'h0);
    @(posedge clk);
    rreg(4'd2); chk("R4 visible after 3 edges", va, 32'h1);
  endtask

  task automatic t_level();
    do_reset();
    settle();
    rreg(4'd6); chk("R5 low level after reset", va, 32'hFFFF_FFFF);
    wreg(4'd6, 32'hFFFF_FFFF);
    rreg(4'd6); chk("R7 active level re-sets", va, 32'hFFFF_FFFF);
    wreg(4'd3, 32'h5555_5555);
    wreg(4'd4, 32'h5555_5555);
    pad_in = 32'h0000_00F0;
    settle();
    wreg(4'd6, 32'hFFFF_FFFF);
    rreg(4'd6); chk("R5 high level", va, 32'h0000_00F0);
  endtask

  task automatic t_edge();
    do_reset();
    wreg(4'd3, 32'hAAAA_AAAA);
    wreg(4'd4, 32'hFFFF_FFFF);
    settle();
    wreg(4'd6, 32'hFFFF_FFFF);
    pad_in = 32'hFFFF_FFFF;
    settle();
    rreg(4'd6); chk("R5 rising low half", va, 32'h0000_FFFF);
    wreg(4'd6, 32'hFFFF_FFFF);
    rreg(4'd6); chk("R7 edge flag clears", va, 32'h0);
    pad_in = 32'h0;
    settle();
    rreg(4'd6); chk("R5 falling high half", va, 32'hFFFF_0000);
    wreg(4'd6, 32'h0001_0000);
    rreg(4'd6); chk("R7 zero bits untouched", va, 32'hFFFE_0000);
    pad_in = 32'hFFFF_FFFF;
    wreg(4'd3, 32'h5555_5555);
    wreg(4'd4, 32'h5555_5559);
    settle();
    wreg(4'd6, 32'hFFFF_FFFF);
    rreg(4'd6); chk("R5 pin17 field position", va, 32'hFFFD_FFFF);
    pad_in = 32'hFFFD_FFFF;
    settle();
    wreg(4'd6, 32'hFFFF_FFFF);
    pad_in = 32'hFFFF_FFFF;
    settle();
    rreg(4'd6); chk("R5 pin17 rising", va, 32'hFFFF_FFFF);
  endtask

  task automatic t_anyedge();
    do_reset();
    wreg(4'd3, 32'hAAAA_AAAA);
    wreg(4'd4, 32'hAAAA_AAAA);
    wreg(4'd7, 32'h0000_0002);
    rreg(4'd7);
    chk("R6 override readback", va, 32'h2);
    chk("R10 absent reads zero", vb, 32'h0);
    pad_in = 32'h0000_0006;
    settle();
    wreg(4'd6, 32'hFFFF_FFFF);
    pad_in = 32'h0;
    settle();
    rreg(4'd6);
    chk("R6 falling flagged by override", va, 32'h2);
    chk("R10 absent write no effect", vb, 32'h0);
  endtask

  task automatic t_outpin();
    do_reset();
    wreg(4'd1, 32'h0000_0001);
    wreg(4'd3, 32'hAAAA_AAAA);
    wreg(4'd4, 32'hAAAA_AAAA);
    settle();
    wreg(4'd6, 32'hFFFF_FFFF);
    pad_in = 32'h0000_0001;
    settle();
    rreg(4'd6); chk("R8 output pin no flag", va, 32'h0);
  endtask

  task automatic t_irq();
    do_reset();
    wreg(4'd3, 32'h5555_5555);
    wreg(4'd4, 32'h5555_5555);
    pad_in = 32'h0001_0001;
    settle();
    wreg(4'd6, 32'hFFFF_FFFF);
    rreg(4'd6); chk("R9 flags", va, 32'h0001_0001);
    chk("R9 masked off", {30'b0, irq_lo, irq_hi}, 32'h0);
    wreg(4'd5, 32'h0001_0000);
    chk("R9 single lo", {31'b0, irq_lo}, 32'h1);
    chk("R9 single hi stays 0", {31'b0, irq_hi}, 32'h0);
    chk("R9 split upper", {30'b0, irq_lo_b, irq_hi_b}, 32'h1);
    wreg(4'd5, 32'h0000_0001);
    chk("R9 split lower", {30'b0, irq_lo_b, irq_hi_b}, 32'h2);
  endtask

  task automatic t_unmapped();
    do_reset();
    wreg(4'd1, 32'h0000_000F);
    wreg(4'd5, 32'h0000_0003);
    wreg(4'd9, 32'hFFFF_FFFF);
    wreg(4'd15, 32'hFFFF_FFFF);
    for (int a = 8; a < 16; a++) begin
      rreg(4'(a)); chk("R11 unmapped read", va, 32'h0);
    end
    rreg(4'd1); chk("R11 dir kept", va, 32'h0000_000F);
    rreg(4'd5); chk("R11 mask kept", va, 32'h0000_0003);
    rreg(4'd0); chk("R11 data kept", va, 32'h0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_output();
    t_sync();
    t_level();
    t_edge();
    t_anyedge();
    t_outpin();
    t_irq();
    t_unmapped();
    finish_run();
  end
endmodule